// File: doc/BRIEF.md
# Receive Descriptor List Sequencer

This block walks a linked list of receive descriptors held in system memory for a packet receive DMA engine. It reads the first four 32-bit words of each descriptor through a single request/response memory port and checks the ownership flag. It then presents the buffer addresses for the data path to fill. When the data path reports that the descriptor's buffers are done, the block writes the status back and releases the descriptor to software by clearing its ownership flag. Descriptors are either four words (normal layout) or eight words (extended layout, with an extra status word and a two-word time stamp).

The next descriptor is found in one of two ways. In ring mode it sits immediately after the current one, and an end-of-ring flag sends the walk back to the base address. In chained mode, word 3 of the current descriptor points to the next one. When a frame ends and time stamping is on, word 3 is reused for the upper half of the captured time stamp. If the block meets a descriptor that software still owns, it parks and raises an unavailable flag until a resume pulse arrives.

Both data-carrying edges use valid/ready handshakes. The memory request port holds address, direction and write data steady while `mreq_valid` is high and `mreq_ready` is low. A transfer happens on a clock edge where both are high. Read data comes back on `mrsp_valid`/`mrsp_ready`, one beat per accepted read, and only one memory access is outstanding at a time. The buffer port holds `buf_valid` and both addresses steady until the data path raises `buf_ready`. The completion fields are sampled on that same edge.

Top module: `rxdesc_seq`

## Requirements
- R1: After reset, `mreq_valid`, `buf_valid`, `mrsp_ready` and `unavail` are low, and every memory address issued has its two low bits at zero (the base address is taken with bits 1:0 cleared).
- R2: A `start` pulse in idle loads the base address. The block then reads descriptor words 0, 1, 2, 3 at byte offsets 0, 4, 8, 12, in that order.
- R3: If word 0 bit 31 (ownership) reads 0, the block issues no further word reads and raises `unavail`. It issues no memory or buffer request until a `resume` pulse, after which it fetches the same descriptor again from word 0.
- R4: `buf1_addr` is word 2 unchanged for the first descriptor after `start` or after one whose completion carried `seg_last`; otherwise it is word 2 with the low ALIGN_BITS bits cleared. In ring mode `buf2_addr` is word 3 with the low ALIGN_BITS bits cleared; in chained mode it is zero.
- R5: When word 1 bit 24 is set (chained), the next descriptor address is word 3 with the low ALIGN_BITS bits cleared.
- R6: When word 1 bit 24 is clear (ring), the next descriptor is the current address plus 16 bytes (`enh_fmt`=0) or 32 bytes (`enh_fmt`=1). If word 1 bit 25 (end of ring) is set, the next descriptor is the base address instead.
- R7: Write-back always ends with word 0 = {1'b0, `seg_status`}, which clears ownership. No write-back word follows it.
- R8: When `ts_en` and `seg_last` are both high at the buffer handshake, word 3 is written with `ts_value[63:32]`. In the extended layout, word 6 also receives `ts_value[31:0]` and word 7 receives `ts_value[63:32]`. Otherwise words 3, 6 and 7 are not written.
- R9: In the extended layout, word 4 is written with `ext_status` before any other word. Write order is word 4, 6, 7, 3, then 0. The normal layout never writes beyond byte offset 12.
- R10: While `mreq_valid` is high and `mreq_ready` low, the request fields hold. While `buf_valid` is high and `buf_ready` low, both buffer addresses hold.
- R11: `buf_valid` and `mreq_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking from `base_addr` (idle only) |
| resume | input | 1 | Leave the unavailable state and refetch |
| base_addr | input | 32 | First descriptor / ring wrap address |
| enh_fmt | input | 1 | 1: eight-word descriptors, 0: four-word |
| ts_en | input | 1 | Time stamp write-back enable |
| mreq_valid | output | 1 | Memory request valid |
| mreq_ready | input | 1 | Memory request accepted |
| mreq_write | output | 1 | 1 write, 0 read |
| mreq_addr | output | 32 | Byte address |
| mreq_wdata | output | 32 | Write data |
| mrsp_valid | input | 1 | Read data valid |
| mrsp_ready | output | 1 | Read data accepted |
| mrsp_data | input | 32 | Read data |
| buf_valid | output | 1 | Buffer addresses valid |
| buf_ready | input | 1 | Data path finished with this descriptor |
| buf1_addr | output | 32 | First buffer address |
| buf2_addr | output | 32 | Second buffer address (ring mode) |
| seg_last | input | 1 | Frame ends in this descriptor |
| seg_status | input | 31 | Status for word 0 bits 30:0 |
| ext_status | input | 32 | Extended status for word 4 |
| ts_value | input | 64 | Captured receive time stamp |
| unavail | output | 1 | Parked on a software-owned descriptor |

## Verification
The bench builds the block with ALIGN_BITS=4, which models a 128-bit bus. Clearing the low bits then removes a whole hex digit, so masked and unmasked buffer and pointer values differ visibly for word-2 and word-3 contents ending in 3, 5, 7, 9 or C.

It runs normal-layout ring walks, covering end-of-ring wrap, a stall with resume, and time stamp write-back. It then runs extended-layout chained walks, a switch back to ring stride inside the extended layout, and a frame end with time stamping off. Each of these exercises the start-of-frame address rule and all three write-back orderings.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;
  localparam int DW         = 32;
  localparam int OWN_BIT    = 31;
  localparam int CHAIN_BIT  = 24;
  localparam int EOR_BIT    = 25;
  localparam int NORM_WORDS = 4;
  localparam int ENH_WORDS  = 8;
  localparam logic [DW-1:0] NORM_BYTES = DW'(NORM_WORDS * 4);
  localparam logic [DW-1:0] ENH_BYTES  = DW'(ENH_WORDS * 4);
  localparam logic [2:0]    LAST_STEP  = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RREQ, ST_RRSP, ST_STALL, ST_BUF, ST_WB
  } seq_state_e;
endpackage

// File: rtl/rxdesc_addr.sv
module rxdesc_addr
  import rxdesc_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic [DW-1:0] cur,
  input  logic [DW-1:0] base,
  input  logic [DW-1:0] word2,
  input  logic [DW-1:0] word3,
  input  logic          chained,
  input  logic          end_ring,
  input  logic          sof,
  input  logic          enh,
  output logic [DW-1:0] buf1,
  output logic [DW-1:0] buf2,
  output logic [DW-1:0] nxt
);
  localparam logic [DW-1:0] LOW_MASK  = (DW'(1) << ALIGN_BITS) - DW'(1);
  localparam logic [DW-1:0] KEEP_MASK = ~LOW_MASK;

  logic [DW-1:0] stride;

  always_comb begin
    stride = enh ? ENH_BYTES : NORM_BYTES;
    buf1   = sof ? word2 : (word2 & KEEP_MASK);
    buf2   = chained ? '0 : (word3 & KEEP_MASK);
    if (chained)       nxt = word3 & KEEP_MASK;
    else if (end_ring) nxt = base;
    else               nxt = cur + stride;
  end
endmodule

// File: rtl/rxdesc_wb.sv
module rxdesc_wb
  import rxdesc_pkg::*;
(
  input  logic [2:0]      step,
  input  logic            enh,
  input  logic            wr_ts,
  input  logic [DW-2:0]   status,
  input  logic [DW-1:0]   ext,
  input  logic [2*DW-1:0] ts,
  output logic            en,
  output logic [2:0]      widx,
  output logic [DW-1:0]   data
);
  always_comb begin
    en   = 1'b0;
    widx = 3'd0;
    data = '0;
    case (step)
      3'd0: begin en = enh;          widx = 3'd4; data = ext;            end
      3'd1: begin en = enh && wr_ts; widx = 3'd6; data = ts[DW-1:0];     end
      3'd2: begin en = enh && wr_ts; widx = 3'd7; data = ts[2*DW-1:DW];  end
      3'd3: begin en = wr_ts;        widx = 3'd3; data = ts[2*DW-1:DW];  end
      default: begin en = 1'b1;      widx = 3'd0; data = {1'b0, status}; end
    endcase
  end
endmodule

// File: rtl/rxdesc_seq.sv
module rxdesc_seq
  import rxdesc_pkg::*;
#(
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          resume,
  input  logic [31:0]   base_addr,
  input  logic          enh_fmt,
  input  logic          ts_en,
  output logic          mreq_valid,
  input  logic          mreq_ready,
  output logic          mreq_write,
  output logic [31:0]   mreq_addr,
  output logic [31:0]   mreq_wdata,
  input  logic          mrsp_valid,
  output logic          mrsp_ready,
  input  logic [31:0]   mrsp_data,
  output logic          buf_valid,
  input  logic          buf_ready,
  output logic [31:0]   buf1_addr,
  output logic [31:0]   buf2_addr,
  input  logic          seg_last,
  input  logic [30:0]   seg_status,
  input  logic [31:0]   ext_status,
  input  logic [63:0]   ts_value,
  output logic          unavail
);
  seq_state_e      st;
  logic [DW-1:0]   cur, base_r, w2, w3, nxt;
  logic            chained, end_ring, sof, wr_ts;
  logic [1:0]      rd_idx;
  logic [2:0]      wb_step, wb_idx;
  logic            wb_en;
  logic [DW-1:0]   wb_data, ext_r;
  logic [DW-2:0]   stat_r;
  logic [2*DW-1:0] ts_r;

  rxdesc_addr #(.ALIGN_BITS(ALIGN_BITS)) u_addr (
    .cur(cur), .base(base_r), .word2(w2), .word3(w3),
    .chained(chained), .end_ring(end_ring), .sof(sof), .enh(enh_fmt),
    .buf1(buf1_addr), .buf2(buf2_addr), .nxt(nxt)
  );

  rxdesc_wb u_wb (
    .step(wb_step), .enh(enh_fmt), .wr_ts(wr_ts), .status(stat_r),
    .ext(ext_r), .ts(ts_r), .en(wb_en), .widx(wb_idx), .data(wb_data)
  );

  always_comb begin
    mreq_valid = 1'b0;
    mreq_write = 1'b0;
    mreq_addr  = cur + {28'd0, rd_idx, 2'b00};
    mreq_wdata = '0;
    mrsp_ready = 1'b0;
    buf_valid  = 1'b0;
    case (st)
      ST_RREQ: mreq_valid = 1'b1;
      ST_RRSP: mrsp_ready = 1'b1;
      ST_BUF:  buf_valid  = 1'b1;
      ST_WB: begin
        mreq_valid = wb_en;
        mreq_write = 1'b1;
        mreq_addr  = cur + {27'd0, wb_idx, 2'b00};
        mreq_wdata = wb_data;
      end
      default: ;
    endcase
  end

  assign unavail = (st == ST_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur      <= '0;
      base_r   <= '0;
      w2       <= '0;
      w3       <= '0;
      chained  <= 1'b0;
      end_ring <= 1'b0;
      sof      <= 1'b1;
      wr_ts    <= 1'b0;
      rd_idx   <= '0;
      wb_step  <= '0;
      stat_r   <= '0;
      ext_r    <= '0;
      ts_r     <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          cur    <= {base_addr[DW-1:2], 2'b00};
          base_r <= {base_addr[DW-1:2], 2'b00};
          rd_idx <= '0;
          sof    <= 1'b1;
          st     <= ST_RREQ;
        end
        ST_RREQ: if (mreq_ready) st <= ST_RRSP;
        ST_RRSP: if (mrsp_valid) begin
          case (rd_idx)
            2'd1: begin chained <= mrsp_data[CHAIN_BIT]; end_ring <= mrsp_data[EOR_BIT]; end
            2'd2: w2 <= mrsp_data;
            2'd3: w3 <= mrsp_data;
            default: ;
          endcase
          if (rd_idx == 2'd0 && !mrsp_data[OWN_BIT]) st <= ST_STALL;
          else if (rd_idx == 2'd3)                   st <= ST_BUF;
          else begin
            rd_idx <= rd_idx + 2'd1;
            st     <= ST_RREQ;
          end
        end
        ST_STALL: if (resume) begin
          rd_idx <= '0;
          st     <= ST_RREQ;
        end
        ST_BUF: if (buf_ready) begin
          wr_ts   <= ts_en && seg_last;
          stat_r  <= seg_status;
          ext_r   <= ext_status;
          ts_r    <= ts_value;
          sof     <= seg_last;
          wb_step <= '0;
          st      <= ST_WB;
        end
        ST_WB: if (!wb_en || mreq_ready) begin
          if (wb_step == LAST_STEP) begin
            cur    <= nxt;
            rd_idx <= '0;
            st     <= ST_RREQ;
          end else begin
            wb_step <= wb_step + 3'd1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxdesc_seq_chk.sv
module rxdesc_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        resume,
  input logic        mreq_valid,
  input logic        mreq_ready,
  input logic        mreq_write,
  input logic [31:0] mreq_addr,
  input logic [31:0] mreq_wdata,
  input logic        mrsp_ready,
  input logic        buf_valid,
  input logic        buf_ready,
  input logic [31:0] buf1_addr,
  input logic [31:0] buf2_addr,
  input logic        unavail
);
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr)
      && $stable(mreq_write) && $stable(mreq_wdata));

  a_r10_buf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf1_addr) && $stable(buf2_addr));

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_valid && mreq_valid));

  a_r3_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    unavail |-> !mreq_valid && !buf_valid);

  a_r3_hold_until_resume: assert property (@(posedge clk) disable iff (!rst_n)
    unavail && !resume |=> unavail);

  a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_valid |-> mreq_addr[1:0] == 2'b00);

  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mrsp_ready |-> !mreq_valid);
endmodule

bind rxdesc_seq rxdesc_seq_chk u_chk (.*);

// File: tb/rxdesc_seq_bench.sv
module rxdesc_seq_bench;
  typedef struct packed {
    logic        wr;
    logic [31:0] a;
    logic [31:0] d;
    logic [15:0] tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, resume = 1'b0, enh_fmt = 1'b0, ts_en = 1'b0;
  logic [31:0] base_addr = '0;
  logic mreq_valid, mreq_write, mrsp_ready, buf_valid, unavail;
  logic mreq_ready = 1'b0, mrsp_valid = 1'b0;
  logic [31:0] mreq_addr, mreq_wdata, buf1_addr, buf2_addr;
  logic [31:0] mrsp_data = '0;
  logic buf_ready = 1'b0, seg_last = 1'b0;
  logic [30:0] seg_status = '0;
  logic [31:0] ext_status = '0;
  logic [63:0] ts_value = '0;

  logic [31:0] mem [0:127];
  logic        poke_en = 1'b0, clr = 1'b0;
  logic [31:0] poke_a = '0, poke_d = '0;
  logic [1:0]  rdy_cnt = '0;
  int compared = 0, mismatched = 0;
  item_t exp_q[$];

  always #10 clk = ~clk;

  rxdesc_seq #(.ALIGN_BITS(4)) u_rxdesc_seq (.*);

  // memory model
  always @(posedge clk) begin
    rdy_cnt    <= rdy_cnt + 2'd1;
    mreq_ready <= (rdy_cnt != 2'd2);
    if (clr) for (int i = 0; i < 128; i++) mem[i] <= '0;
    if (poke_en) mem[poke_a[8:2]] <= poke_d;
    if (mrsp_valid && mrsp_ready) mrsp_valid <= 1'b0;
    if (mreq_valid && mreq_ready) begin
      if (mreq_write) mem[mreq_addr[8:2]] <= mreq_wdata;
      else begin
        mrsp_valid <= 1'b1;
        mrsp_data  <= mem[mreq_addr[8:2]];
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mreq_valid && mreq_ready) begin
      if (exp_q.size() == 0) begin
        mismatched++;
        compared++;
        $display("FAIL unexpected request wr=%0b addr=%h (expected none) R3", mreq_write, mreq_addr);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        compared++;
        if (mreq_write !== e.wr || mreq_addr !== e.a || (e.wr && mreq_wdata !== e.d)) begin
          mismatched++;
          $display("FAIL %s req wr=%0b addr=%h data=%h expected wr=%0b addr=%h data=%h",
                   e.tag, mreq_write, mreq_addr, mreq_wdata, e.wr, e.a, e.d);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic push_fetch(input logic [31:0] a, input logic [15:0] tag, input int n);
    for (int i = 0; i < n; i++) exp_q.push_back('{1'b0, a + 32'(4 * i), 32'd0, tag});
  endtask

  task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input logic [15:0] tag);
    exp_q.push_back('{1'b1, a, d, tag});
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic serve(input logic [31:0] e1, input logic [31:0] e2, input logic last,
                       input logic [30:0] st, input logic [31:0] ex, input logic [63:0] ts);
    @(negedge clk);
    while (!buf_valid) @(negedge clk);
    check("R4 buf1_addr", buf1_addr, e1);
    check("R4 buf2_addr", buf2_addr, e2);
    repeat (2) @(negedge clk);
    buf_ready = 1'b1; seg_last = last; seg_status = st; ext_status = ex; ts_value = ts;
    @(negedge clk);
    buf_ready = 1'b0;
  endtask

  task automatic wait_stall();
    @(negedge clk);
    while (!unavail) @(negedge clk);
    check("R3 unavail raised", {31'd0, unavail}, 32'd1);
    repeat (8) @(negedge clk);
    check("R3 no request while parked", {31'd0, mreq_valid}, 32'd0);
    check("R3 queue drained", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired (R2 progress) actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    // R1 reset state
    check("R1 mreq_valid", {31'd0, mreq_valid}, 32'd0);
    check("R1 buf_valid", {31'd0, buf_valid}, 32'd0);
    check("R1 unavail", {31'd0, unavail}, 32'd0);
    check("R1 mrsp_ready", {31'd0, mrsp_ready}, 32'd0);

    // scenario A: normal layout, ring mode
    poke(32'h40, 32'h8000_0000); poke(32'h44, 32'h0);
    poke(32'h48, 32'h103);       poke(32'h4C, 32'h127);
    poke(32'h50, 32'h8000_0000); poke(32'h54, 32'h0200_0000);
    poke(32'h58, 32'h145);       poke(32'h5C, 32'h158);
    enh_fmt = 1'b0; ts_en = 1'b1; base_addr = 32'h40;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    push_fetch(32'h40, "R2", 4);
    pulse_start();
    push_wr(32'h40, 32'h11, "R7");
    push_fetch(32'h50, "R6", 4);
    serve(32'h103, 32'h120, 1'b0, 31'h11, 32'h0, 64'h0);
    push_wr(32'h5C, 32'hAAAA_BBBB, "R8");
    push_wr(32'h50, 32'h22, "R7");
    push_fetch(32'h40, "R6", 1);
    serve(32'h140, 32'h150, 1'b1, 31'h22, 32'h0, 64'hAAAA_BBBB_CCCC_DDDD);
    wait_stall();
    poke(32'h40, 32'h8000_0000);
    push_fetch(32'h40, "R3", 4);
    @(negedge clk); resume = 1'b1;
    @(negedge clk); resume = 1'b0;
    push_wr(32'h4C, 32'h1111_2222, "R8");
    push_wr(32'h40, 32'h33, "R7");
    push_fetch(32'h50, "R6", 1);
    serve(32'h103, 32'h120, 1'b1, 31'h33, 32'h0, 64'h1111_2222_3333_4444);
    wait_stall();

    // scenario B: extended layout, chained then ring
    @(negedge clk); rst_n = 1'b0;
    poke(32'h100, 32'h8000_0000); poke(32'h104, 32'h0100_0000);
    poke(32'h108, 32'h1E6);       poke(32'h10C, 32'h147);
    poke(32'h140, 32'h8000_0000); poke(32'h144, 32'h0100_0000);
    poke(32'h148, 32'h1F9);       poke(32'h14C, 32'h18C);
    poke(32'h180, 32'h8000_0000); poke(32'h184, 32'h0);
    poke(32'h188, 32'h1A0);       poke(32'h18C, 32'h1B5);
    enh_fmt = 1'b1; ts_en = 1'b1; base_addr = 32'h100;
    @(negedge clk); rst_n = 1'b1;
    push_fetch(32'h100, "R2", 4);
    pulse_start();
    push_wr(32'h110, 32'h55, "R9");
    push_wr(32'h100, 32'h44, "R7");
    push_fetch(32'h140, "R5", 4);
    serve(32'h1E6, 32'h0, 1'b0, 31'h44, 32'h55, 64'h0);
    push_wr(32'h150, 32'h77, "R9");
    push_wr(32'h158, 32'h89AB_CDEF, "R8");
    push_wr(32'h15C, 32'h0123_4567, "R8");
    push_wr(32'h14C, 32'h0123_4567, "R8");
    push_wr(32'h140, 32'h66, "R7");
    push_fetch(32'h180, "R5", 4);
    serve(32'h1F0, 32'h0, 1'b1, 31'h66, 32'h77, 64'h0123_4567_89AB_CDEF);
    ts_en = 1'b0;
    push_wr(32'h190, 32'h99, "R9");
    push_wr(32'h180, 32'h88, "R7");
    push_fetch(32'h1A0, "R6", 1);
    serve(32'h1A0, 32'h1B0, 1'b1, 31'h88, 32'h99, 64'hFFFF_EEEE_DDDD_CCCC);
    wait_stall();

    // final descriptor contents
    check("R7 word0 @40", mem[32'h40 >> 2], 32'h33);
    check("R8 word3 @4C", mem[32'h4C >> 2], 32'h1111_2222);
    check("R7 word0 @50", mem[32'h50 >> 2], 32'h22);
    check("R8 word3 @5C", mem[32'h5C >> 2], 32'hAAAA_BBBB);
    check("R8 word3 kept @10C", mem[32'h10C >> 2], 32'h147);
    check("R9 word4 @110", mem[32'h110 >> 2], 32'h55);
    check("R8 word6 @158", mem[32'h158 >> 2], 32'h89AB_CDEF);
    check("R8 word7 @15C", mem[32'h15C >> 2], 32'h0123_4567);
    check("R8 word3 kept @18C", mem[32'h18C >> 2], 32'h1B5);
    check("R8 word6 kept @198", mem[32'h198 >> 2], 32'h0);
    check("R8 word7 kept @19C", mem[32'h19C >> 2], 32'h0);
    check("R7 word0 @180", mem[32'h180 >> 2], 32'h88);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule